// File: doc/BRIEF.md
# Neighbor-Coupled Microcoded Cell Processor

This block is one processing element of a grid solver. It runs a short microprogram held in a unified 256 x 40-bit RAM. The same RAM holds the instructions, the cell's state value, the constants and the partial results. Each pass through the program computes one time step of a discretized update for one grid point. The pass uses the cell's own value and the values of its four neighbours at distances -2, -1, +1 and +2.

The cell publishes its own value on a 32-bit status output so that neighbouring cells can read it. It holds four 32-bit neighbour input registers, which load on a sample strobe between iterations. Arithmetic is signed Q16.16 fixed point.

Configuration words arrive over a valid/ready port. A word is accepted on a cycle where both `cfg_valid` and `cfg_ready` are high. `cfg_ready` is high only while the cell is idle, so a host can hold a word until the iteration in progress finishes.

A one-cycle `go` pulse starts one iteration from the current program counter. The iteration ends when a JUMP executes. At that point `iter_done` pulses and the cell returns to idle. An array controller pulses `go` on all cells together, so the whole array steps in lockstep.

Top module: `nbr_cell_core`

## Requirements
- R1: After reset, `pub_status` is 0, `iter_done` is 0, `cfg_ready` is 1, the program counter is 0 and the four neighbour registers are 0.
- R2: A configuration word writes RAM[`cfg_addr`] on a cycle where `cfg_valid` and `cfg_ready` are both high. `cfg_ready` is low from the cycle after the `go` edge until the iteration ends.
- R3: An instruction word places its 6-bit opcode in bits [39:34] and its RAM address in bits [7:0]. Every instruction takes 2 fetch cycles followed by its execute cycles. A `go` captured while idle starts fetching at the program counter, and the counter advances by one per instruction.
- R4: Opcodes and execute cycles are as follows:
  - 000000 fetch-no-op: 2 cycles
  - 000001 load A: 2 cycles
  - 000010 load B: 2 cycles
  - 000011 publish: 2 cycles
  - 000100 store C: 1 cycle
  - 000101, 000110, 000111, 001000 store neighbour -2, -1, +1, +2: 2 cycles each
  - 001001 add: 8 cycles
  - 001010 subtract: 8 cycles
  - 001011 multiply: 6 cycles
  - 001100 jump: 1 cycle
- R5: Add computes C = A + B and subtract computes C = A - B. Both are signed 32-bit Q16.16 with two's-complement wrap.
- R6: Multiply sets C to bits [47:16] of the signed 64-bit product A*B.
- R7: The publish opcode copies bits [31:0] of the addressed RAM word to `pub_status`.
- R8: The four neighbour-store opcodes write the selected neighbour register, zero-extended, to the addressed RAM word. Store C writes C the same way.
- R9: `nbr_sample` loads all four neighbour inputs only while the cell is idle. While an iteration runs, the strobe has no effect.
- R10: Jump loads the program counter from the address field and ends the iteration. `iter_done` is high for exactly one cycle after the edge on which the jump executes.
- R11: Opcode 000000 does nothing for its 2 execute cycles. Any undefined opcode does nothing for 1 execute cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration word offered |
| cfg_ready | output | 1 | Configuration word can be taken (cell idle) |
| cfg_addr | input | 8 | RAM address of the configuration word |
| cfg_data | input | 40 | Configuration word |
| go | input | 1 | Start one iteration (honoured while idle) |
| nbr_sample | input | 1 | Load the neighbour inputs (honoured while idle) |
| nbr_m2 | input | 32 | Value of neighbour at distance -2 |
| nbr_m1 | input | 32 | Value of neighbour at distance -1 |
| nbr_p1 | input | 32 | Value of neighbour at distance +1 |
| nbr_p2 | input | 32 | Value of neighbour at distance +2 |
| pub_status | output | 32 | Published own state value |
| iter_done | output | 1 | One-cycle pulse when an iteration ends |

## Verification
An iteration that is captured on the `go` edge raises `iter_done` after 1 + Σ(2 + execute cycles) rising edges, counting the capture edge as the first. The bench computes this sum from the R4 table for every program it loads and compares it with the edge count it observes. `pub_status` and `iter_done` are both registered, so the bench samples them on the falling edge after the edge that ends the iteration. The published result is therefore compared in the same half-cycle in which `iter_done` is first seen high. Strobes that should be ignored are driven in the first fetch cycle after `go`, and their effect is read back through the publish opcode after the iteration ends.

// File: rtl/cell_pkg.sv
package cell_pkg;
  localparam int DATA_W = 32;
  localparam int WORD_W = 40;
  localparam int ADDR_W = 8;
  localparam int OP_W   = 6;
  localparam int OP_LSB = WORD_W - OP_W;
  localparam int CNT_W  = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 6'h00,
    OP_LDA  = 6'h01,
    OP_LDB  = 6'h02,
    OP_PUB  = 6'h03,
    OP_STC  = 6'h04,
    OP_SNM2 = 6'h05,
    OP_SNM1 = 6'h06,
    OP_SNP1 = 6'h07,
    OP_SNP2 = 6'h08,
    OP_ADD  = 6'h09,
    OP_SUB  = 6'h0A,
    OP_MUL  = 6'h0B,
    OP_JMP  = 6'h0C
  } opcode_e;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_MUL} alu_kind_e;

  typedef enum logic [1:0] {S_IDLE, S_F0, S_F1, S_EX} seq_state_e;

  function automatic logic [CNT_W-1:0] exec_cycles(input logic [OP_W-1:0] op);
    case (op)
      OP_NOP, OP_LDA, OP_LDB, OP_PUB,
      OP_SNM2, OP_SNM1, OP_SNP1, OP_SNP2: exec_cycles = 4'd2;
      OP_ADD, OP_SUB:                      exec_cycles = 4'd8;
      OP_MUL:                              exec_cycles = 4'd6;
      default:                             exec_cycles = 4'd1;
    endcase
  endfunction
endpackage

// File: rtl/cell_ram.sv
module cell_ram #(
  parameter int AW = 8,
  parameter int DW = 40
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  assign rd_data = store[rd_addr];
endmodule

// File: rtl/cell_alu.sv
module cell_alu
  import cell_pkg::*;
#(
  parameter int W = 32,
  parameter int FRAC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  alu_kind_e        kind,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  output logic             fin,
  output logic [W-1:0]     res
);
  localparam int PW = 2 * W;

  logic [W-1:0]     opa, opb;
  alu_kind_e        kind_q;
  logic             busy;
  logic [CNT_W-1:0] rem;
  logic signed [PW-1:0] prod;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opa    <= '0;
      opb    <= '0;
      kind_q <= ALU_ADD;
      busy   <= 1'b0;
      rem    <= '0;
    end else if (start) begin
      opa    <= a;
      opb    <= b;
      kind_q <= kind;
      busy   <= 1'b1;
      rem    <= (kind == ALU_MUL) ? exec_cycles(OP_MUL) - 4'd2
                                  : exec_cycles(OP_ADD) - 4'd2;
    end else if (busy) begin
      if (rem == '0) busy <= 1'b0;
      else           rem  <= rem - 4'd1;
    end
  end

  assign prod = $signed(opa) * $signed(opb);
  assign fin  = busy && (rem == '0);

  always_comb begin
    case (kind_q)
      ALU_SUB: res = opa - opb;
      ALU_MUL: res = prod[FRAC+W-1:FRAC];
      default: res = opa + opb;
    endcase
  end

  // R5
  alu_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
endmodule

// File: rtl/cell_nbr_bank.sv
module cell_nbr_bank #(
  parameter int W = 32,
  parameter int N = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample,
  input  logic                busy,
  input  logic [N-1:0][W-1:0] d,
  output logic [N-1:0][W-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)                q[g] <= '0;
      else if (sample && !busy)  q[g] <= d[g];
    end
  end

  // R9
  nbr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(q));
endmodule

// File: rtl/nbr_cell_core.sv
module nbr_cell_core
  import cell_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_valid,
  output logic        cfg_ready,
  input  logic [7:0]  cfg_addr,
  input  logic [39:0] cfg_data,
  input  logic        go,
  input  logic        nbr_sample,
  input  logic [31:0] nbr_m2,
  input  logic [31:0] nbr_m1,
  input  logic [31:0] nbr_p1,
  input  logic [31:0] nbr_p2,
  output logic [31:0] pub_status,
  output logic        iter_done
);
  localparam int NNBR = 4;
  localparam int PAD  = WORD_W - DATA_W;

  seq_state_e        state;
  logic [ADDR_W-1:0] pc, ir_addr;
  logic [OP_W-1:0]   ir_op;
  logic [CNT_W-1:0]  cnt;
  logic              ex_first;
  logic [DATA_W-1:0] a_reg, b_reg, c_reg;

  logic [WORD_W-1:0] rd_data, core_wdata, ram_wdata;
  logic [ADDR_W-1:0] rd_addr, ram_waddr;
  logic              core_we, cfg_fire, ram_we, ex_last;
  logic              alu_start, alu_fin, is_arith;
  logic [DATA_W-1:0] alu_res;
  alu_kind_e         alu_kind;
  logic [NNBR-1:0][DATA_W-1:0] nbr_d, nbr_q;

  assign cfg_ready = (state == S_IDLE);
  assign cfg_fire  = cfg_valid && cfg_ready;
  assign ex_last   = (state == S_EX) && (cnt == '0);
  assign rd_addr   = (state == S_EX) ? ir_addr : pc;

  always_comb begin
    core_we    = 1'b0;
    core_wdata = '0;
    if (ex_last) begin
      case (ir_op)
        OP_STC:  begin core_we = 1'b1; core_wdata = {{PAD{1'b0}}, c_reg};    end
        OP_SNM2: begin core_we = 1'b1; core_wdata = {{PAD{1'b0}}, nbr_q[0]}; end
        OP_SNM1: begin core_we = 1'b1; core_wdata = {{PAD{1'b0}}, nbr_q[1]}; end
        OP_SNP1: begin core_we = 1'b1; core_wdata = {{PAD{1'b0}}, nbr_q[2]}; end
        OP_SNP2: begin core_we = 1'b1; core_wdata = {{PAD{1'b0}}, nbr_q[3]}; end
        default: ;
      endcase
    end
  end

  assign ram_we    = cfg_fire || core_we;
  assign ram_waddr = cfg_fire ? cfg_addr : ir_addr;
  assign ram_wdata = cfg_fire ? cfg_data : core_wdata;

  cell_ram #(.AW(ADDR_W), .DW(WORD_W)) u_ram (
    .clk     (clk),
    .wr_en   (ram_we),
    .wr_addr (ram_waddr),
    .wr_data (ram_wdata),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  always_comb begin
    is_arith = 1'b1;
    alu_kind = ALU_ADD;
    case (ir_op)
      OP_ADD:  alu_kind = ALU_ADD;
      OP_SUB:  alu_kind = ALU_SUB;
      OP_MUL:  alu_kind = ALU_MUL;
      default: is_arith = 1'b0;
    endcase
  end

  assign alu_start = (state == S_EX) && ex_first && is_arith;

  cell_alu #(.W(DATA_W), .FRAC(DATA_W/2)) u_alu (
    .clk   (clk),
    .rst_n (rst_n),
    .start (alu_start),
    .kind  (alu_kind),
    .a     (a_reg),
    .b     (b_reg),
    .fin   (alu_fin),
    .res   (alu_res)
  );

  assign nbr_d = {nbr_p2, nbr_p1, nbr_m1, nbr_m2};

  cell_nbr_bank #(.W(DATA_W), .N(NNBR)) u_nbr (
    .clk    (clk),
    .rst_n  (rst_n),
    .sample (nbr_sample),
    .busy   (state != S_IDLE),
    .d      (nbr_d),
    .q      (nbr_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      pc         <= '0;
      ir_op      <= '0;
      ir_addr    <= '0;
      cnt        <= '0;
      ex_first   <= 1'b0;
      a_reg      <= '0;
      b_reg      <= '0;
      c_reg      <= '0;
      pub_status <= '0;
      iter_done  <= 1'b0;
    end else begin
      iter_done <= 1'b0;
      case (state)
        S_IDLE: if (go) state <= S_F0;
        S_F0: begin
          ir_op   <= rd_data[WORD_W-1:OP_LSB];
          ir_addr <= rd_data[ADDR_W-1:0];
          state   <= S_F1;
        end
        S_F1: begin
          pc       <= pc + 1'b1;
          cnt      <= exec_cycles(ir_op) - 4'd1;
          ex_first <= 1'b1;
          state    <= S_EX;
        end
        S_EX: begin
          ex_first <= 1'b0;
          if (cnt != '0) begin
            cnt <= cnt - 4'd1;
          end else begin
            state <= S_F0;
            case (ir_op)
              OP_LDA: a_reg      <= rd_data[DATA_W-1:0];
              OP_LDB: b_reg      <= rd_data[DATA_W-1:0];
              OP_PUB: pub_status <= rd_data[DATA_W-1:0];
              OP_ADD, OP_SUB, OP_MUL: c_reg <= alu_res;
              OP_JMP: begin
                pc        <= ir_addr;
                iter_done <= 1'b1;
                state     <= S_IDLE;
              end
              default: ;
            endcase
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2
  always_comb begin
    cfg_core_excl_chk: assert (!(cfg_fire && core_we) || !rst_n);
  end

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !go) |=> (state == S_IDLE) && $stable(pc));

  // R5
  alu_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alu_fin |-> ex_last);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iter_done |=> !iter_done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iter_done |-> cfg_ready);
endmodule

// File: tb/nbr_cell_core_test.sv
module nbr_cell_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic        cfg_ready;
  logic [7:0]  cfg_addr = '0;
  logic [39:0] cfg_data = '0;
  logic        go = 1'b0;
  logic        nbr_sample = 1'b0;
  logic [31:0] nbr_m2 = '0, nbr_m1 = '0, nbr_p1 = '0, nbr_p2 = '0;
  logic [31:0] pub_status;
  logic        iter_done;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  nbr_cell_core uut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .go(go), .nbr_sample(nbr_sample),
    .nbr_m2(nbr_m2), .nbr_m1(nbr_m1), .nbr_p1(nbr_p1), .nbr_p2(nbr_p2),
    .pub_status(pub_status), .iter_done(iter_done)
  );

  // R4 opcode encodings
  localparam logic [5:0] C_NOP = 6'h00, C_LDA = 6'h01, C_LDB = 6'h02, C_PUB = 6'h03,
    C_STC = 6'h04, C_SNM2 = 6'h05, C_SNM1 = 6'h06, C_SNP1 = 6'h07, C_SNP2 = 6'h08,
    C_ADD = 6'h09, C_SUB = 6'h0A, C_MUL = 6'h0B, C_JMP = 6'h0C, C_BAD = 6'h3F;

  // {opcode, A, B, expected C} in Q16.16
  localparam logic [101:0] VEC [6] = '{
    {C_ADD, 32'h0002_0000, 32'h0001_8000, 32'h0003_8000},
    {C_SUB, 32'h0002_0000, 32'h0001_8000, 32'h0000_8000},
    {C_MUL, 32'h0002_0000, 32'h0001_8000, 32'h0003_0000},
    {C_MUL, 32'hFFFF_0000, 32'h0002_8000, 32'hFFFD_8000},
    {C_SUB, 32'h0001_0000, 32'h0002_8000, 32'hFFFE_8000},
    {C_ADD, 32'h7FFF_0000, 32'h0001_0000, 32'h8000_0000}
  };

  function automatic int lat(input logic [5:0] op);
    case (op)
      C_NOP, C_LDA, C_LDB, C_PUB, C_SNM2, C_SNM1, C_SNP1, C_SNP2: lat = 2;
      C_ADD, C_SUB: lat = 8;
      C_MUL: lat = 6;
      default: lat = 1;
    endcase
  endfunction

  function automatic logic [39:0] ins(input logic [5:0] op, input logic [7:0] ad);
    ins = {op, 26'd0, ad};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] ad, input logic [39:0] d);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_addr = ad; cfg_data = d;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  // Runs one iteration; returns the number of rising edges from the go capture
  // edge (counted as 1) to the edge after which iter_done is seen high.
  task automatic run(input bit poke, output int cyc);
    @(negedge clk);
    go = 1'b1; cyc = 0;
    @(posedge clk); cyc = 1;
    @(negedge clk);
    go = 1'b0;
    if (poke) begin
      // R2: not ready while running; R9: strobe ignored while running
      check("R2 cfg_ready low while running", {31'd0, cfg_ready}, 32'd0);
      nbr_sample = 1'b1;
      nbr_m2 = 32'hDEAD_0001; nbr_m1 = 32'hDEAD_0002;
      nbr_p1 = 32'hDEAD_0003; nbr_p2 = 32'hDEAD_0004;
      @(posedge clk); cyc++;
      @(negedge clk);
      nbr_sample = 1'b0;
    end
    while (!iter_done && cyc < 500) begin
      @(posedge clk); cyc++;
      @(negedge clk);
    end
  endtask

  task automatic sample_nbrs(input logic [31:0] a, b, c, d);
    @(negedge clk);
    nbr_sample = 1'b1; nbr_m2 = a; nbr_m1 = b; nbr_p1 = c; nbr_p2 = d;
    @(negedge clk);
    nbr_sample = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int cyc;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pub_status", pub_status, 32'd0);
    check("R1 iter_done", {31'd0, iter_done}, 32'd0);
    check("R1 cfg_ready", {31'd0, cfg_ready}, 32'd1);
    rst_n = 1'b1;

    // R1 neighbour registers are zero: store -2 and publish it
    wr(8'h00, ins(C_SNM2, 8'h90));
    wr(8'h01, ins(C_PUB, 8'h90));
    wr(8'h02, ins(C_JMP, 8'h00));
    wr(8'h90, 40'hFF_FFFF_FFFF);
    run(1'b0, cyc);
    check("R1 neighbour reg reset value", pub_status, 32'd0);
    check("R3 cycles store/publish/jump", cyc, 1 + (2+2) + (2+2) + (2+1));

    // Vector table: R5 add/sub, R6 mul, R8 store C, R7 publish, R4 latencies
    wr(8'h00, ins(C_LDA, 8'h80));
    wr(8'h01, ins(C_LDB, 8'h81));
    wr(8'h03, ins(C_STC, 8'h82));
    wr(8'h04, ins(C_PUB, 8'h82));
    wr(8'h05, ins(C_JMP, 8'h00));
    for (int i = 0; i < 6; i++) begin
      logic [5:0] op;
      op = VEC[i][101:96];
      wr(8'h02, ins(op, 8'h00));
      wr(8'h80, {8'h00, VEC[i][95:64]});
      wr(8'h81, {8'h00, VEC[i][63:32]});
      run(1'b0, cyc);
      check((op == C_MUL) ? "R6 multiply result" : "R5 add/sub result",
            pub_status, VEC[i][31:0]);
      check("R4 iteration cycle count", cyc, 1 + 20 + lat(op));
      @(negedge clk);
      check("R10 iter_done single cycle", {31'd0, iter_done}, 32'd0);
    end

    // R8, R9: each neighbour store, sampled while idle, strobe ignored while running
    sample_nbrs(32'h1111_0001, 32'h2222_0002, 32'h3333_0003, 32'h4444_0004);
    wr(8'h01, ins(C_PUB, 8'h90));
    wr(8'h02, ins(C_JMP, 8'h00));
    wr(8'h00, ins(C_SNM2, 8'h90));
    run(1'b1, cyc);
    check("R9 strobe while running ignored (-2)", pub_status, 32'h1111_0001);
    wr(8'h00, ins(C_SNM1, 8'h90));
    run(1'b0, cyc);
    check("R8 store neighbour -1", pub_status, 32'h2222_0002);
    wr(8'h00, ins(C_SNP1, 8'h90));
    run(1'b0, cyc);
    check("R8 store neighbour +1", pub_status, 32'h3333_0003);
    wr(8'h00, ins(C_SNP2, 8'h90));
    run(1'b0, cyc);
    check("R8 store neighbour +2", pub_status, 32'h4444_0004);
    // R9 idle sample takes effect
    sample_nbrs(32'h0BAD_CAFE, 32'h0, 32'h0, 32'h0);
    wr(8'h00, ins(C_SNM2, 8'h90));
    run(1'b0, cyc);
    check("R9 idle sample captured", pub_status, 32'h0BAD_CAFE);

    // R11 fetch-no-op and undefined opcode
    wr(8'h80, {8'hAB, 32'h1234_5678});
    wr(8'h00, ins(C_PUB, 8'h80));
    wr(8'h01, ins(C_NOP, 8'h80));
    wr(8'h02, ins(C_JMP, 8'h00));
    run(1'b0, cyc);
    check("R11 no-op keeps result", pub_status, 32'h1234_5678);
    check("R11 no-op cycle count", cyc, 1 + 4 + 4 + 3);
    wr(8'h01, ins(C_BAD, 8'h80));
    run(1'b0, cyc);
    check("R11 undefined opcode cycle count", cyc, 1 + 4 + 3 + 3);

    // R10 jump target other than 0, then R3 next go starts there
    wr(8'h81, {8'h00, 32'h0000_5A5A});
    wr(8'h02, ins(C_JMP, 8'h10));
    wr(8'h10, ins(C_PUB, 8'h81));
    wr(8'h11, ins(C_JMP, 8'h00));
    run(1'b0, cyc);
    check("R10 jump ends iteration", pub_status, 32'h1234_5678);
    run(1'b0, cyc);
    check("R10 jump target honoured", pub_status, 32'h0000_5A5A);
    check("R3 resumed at target cycles", cyc, 1 + 4 + 3);

    // R2 write accepted when idle
    check("R2 cfg_ready idle", {31'd0, cfg_ready}, 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule